// File: doc/BRIEF.md
# Horizontal Drive Start-Up Sequencer

This block decides when the horizontal deflection drive may run. After a power-on reset the drive stays off and a status flag reports that the reset happened. Software must first write every configuration register. Only when every subaddress in the valid range has received at least one byte does the block ask the line oscillator for a calibration. Once calibration reports the correct frequency, the drive is released through a soft-start phase. During soft start the output runs at twice the line rate for a set number of line periods. The drive then settles into normal operation.

If the phase detector reports loss of lock while running, the block performs a soft stop, again at the doubled rate for the same number of lines. It then drops the drive and requests a fresh calibration. The drive enable is always masked while the flyback pulse is present. The oscillator, the phase loops and the register storage lie outside this block. It only watches the write strobes and the calibration and lock flags, and it drives the enable, the rate select and the calibration request.

Top module: `hds_seq`

## Requirements
- R1: While reset is asserted and directly after it, drv_en_o, dbl_rate_o and cal_req_o are 0 and por_flag_o is 1.
- R2: por_flag_o stays 1 until the first cycle with stat_rd_i high after reset. From the next cycle it reads 0, and it stays 0 until the next reset.
- R3: A write covers subaddress numbers 0 to NUM_SUB-1. sub_load_i loads the write pointer from sub_i. Each byte_wr_i marks the addressed subaddress as written and advances the pointer by one, wrapping at 2^SUB_W. When sub_load_i and byte_wr_i arrive in the same cycle, the byte goes to sub_i. Writes at or above NUM_SUB mark nothing.
- R4: cal_req_o rises on the second clock edge after the byte that completes the written set. It stays high until a cycle in which cal_done_i is high.
- R5: drv_en_o stays 0 from reset until calibration has reported done, and it is 0 whenever cal_req_o is 1.
- R6: On the edge that sees cal_done_i high during a calibration request, the soft-start phase begins. drv_en_o and dbl_rate_o are 1. dbl_rate_o returns to 0 on the edge that takes the SOFT_LINES-th line_tick_i of the phase.
- R7: In normal running, a cycle with locked_i low starts the soft stop. dbl_rate_o is 1 with the drive on for SOFT_LINES line ticks. After that the drive turns off and cal_req_o is 1 again.
- R8: drv_en_o is 0 in any cycle with flyback_i high, in the same cycle.
- R9: locked_i has no effect during soft start.
- R10: A reset at any time returns every output to its R1 value and clears the written set, so the full write set is needed again.
- R11: Line ticks that occur outside the soft-start and soft-stop phases do not count toward either phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sub_load_i | input | 1 | Load write pointer from sub_i |
| sub_i | input | SUB_W | Subaddress of a new write transfer |
| byte_wr_i | input | 1 | One data byte written at the pointer |
| line_tick_i | input | 1 | One pulse per line period |
| cal_done_i | input | 1 | Oscillator frequency reported correct |
| locked_i | input | 1 | Coincidence detector reports lock |
| flyback_i | input | 1 | Flyback pulse present |
| stat_rd_i | input | 1 | Status byte read strobe |
| drv_en_o | output | 1 | Horizontal drive enable |
| dbl_rate_o | output | 1 | Select doubled line rate (soft start/stop) |
| cal_req_o | output | 1 | Request oscillator calibration |
| por_flag_o | output | 1 | Power-on-reset status flag |

## Verification
The bench writes every subaddress but the last, and the check is that no calibration is requested early. A sequencer that counted writes instead of tracking addresses would start on this pattern. Writes above the valid range, and writes that wrap through the top of the pointer, are mixed in for the same reason. The bench also places line ticks during calibration and drops lock during soft start. A counter that is not cleared would cut the soft start short, and a sequencer that watched lock too early would jump into soft stop. A mid-run reset then checks that the earlier writes no longer count.

// File: rtl/hds_pkg.sv
package hds_pkg;
    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_CAL   = 3'd1,
        ST_START = 3'd2,
        ST_RUN   = 3'd3,
        ST_STOP  = 3'd4
    } seq_st_e;
endpackage

// File: rtl/hds_wr_track.sv
// Tracks which configuration subaddresses have been written since reset.
module hds_wr_track #(
    parameter int NUM_SUB = 20,
    parameter int SUB_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_load_i,
    input  logic [SUB_W-1:0] sub_i,
    input  logic             byte_wr_i,
    output logic             all_written_o
);
    typedef struct packed {
        logic [SUB_W-1:0]   ptr;
        logic [NUM_SUB-1:0] seen;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [SUB_W-1:0] addr;

    always_comb begin
        trk_d = trk_q;
        addr  = sub_load_i ? sub_i : trk_q.ptr;
        if (sub_load_i) trk_d.ptr = sub_i;
        if (byte_wr_i) begin
            for (int i = 0; i < NUM_SUB; i++) begin
                if (addr == SUB_W'(i)) trk_d.seen[i] = 1'b1;
            end
            trk_d.ptr = addr + SUB_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign all_written_o = &trk_q.seen;
endmodule

// File: rtl/hds_line_timer.sv
// Counts line ticks while running; done on the LINES-th tick.
module hds_line_timer #(
    parameter int LINES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = (LINES > 1) ? $clog2(LINES) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = run_i && tick_i && (cnt_q == CW'(LINES - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || done_o) cnt_d = '0;
        else if (tick_i)      cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hds_seq.sv
module hds_seq
    import hds_pkg::*;
#(
    parameter int NUM_SUB    = 20,
    parameter int SUB_W      = 8,
    parameter int SOFT_LINES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_load_i,
    input  logic [SUB_W-1:0] sub_i,
    input  logic             byte_wr_i,
    input  logic             line_tick_i,
    input  logic             cal_done_i,
    input  logic             locked_i,
    input  logic             flyback_i,
    input  logic             stat_rd_i,
    output logic             drv_en_o,
    output logic             dbl_rate_o,
    output logic             cal_req_o,
    output logic             por_flag_o
);
    typedef struct packed {
        seq_st_e st;
        logic    por;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic all_written;
    logic soft_phase;
    logic soft_done;

    hds_wr_track #(.NUM_SUB(NUM_SUB), .SUB_W(SUB_W)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .sub_load_i    (sub_load_i),
        .sub_i         (sub_i),
        .byte_wr_i     (byte_wr_i),
        .all_written_o (all_written)
    );

    assign soft_phase = (ctl_q.st == ST_START) || (ctl_q.st == ST_STOP);

    hds_line_timer #(.LINES(SOFT_LINES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (soft_phase),
        .tick_i (line_tick_i),
        .done_o (soft_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (stat_rd_i) ctl_d.por = 1'b0;
        case (ctl_q.st)
            ST_WAIT:  if (all_written) ctl_d.st = ST_CAL;
            ST_CAL:   if (cal_done_i)  ctl_d.st = ST_START;
            ST_START: if (soft_done)   ctl_d.st = ST_RUN;
            ST_RUN:   if (!locked_i)   ctl_d.st = ST_STOP;
            ST_STOP:  if (soft_done)   ctl_d.st = ST_CAL;
            default:                   ctl_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_WAIT;
            ctl_q.por <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign drv_en_o   = (soft_phase || ctl_q.st == ST_RUN) && !flyback_i;
    assign dbl_rate_o = soft_phase;
    assign cal_req_o  = (ctl_q.st == ST_CAL);
    assign por_flag_o = ctl_q.por;
endmodule

// File: rtl/hds_seq_chk.sv
module hds_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cal_done_i,
    input logic flyback_i,
    input logic stat_rd_i,
    input logic drv_en_o,
    input logic dbl_rate_o,
    input logic cal_req_o,
    input logic por_flag_o
);
    // R8: flyback masks the drive in the same cycle
    p_flyback_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flyback_i |-> !drv_en_o);

    // R5: no drive while calibration is requested
    p_cal_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req_o |-> (!drv_en_o && !dbl_rate_o));

    // R6: doubled rate only with the drive phase active
    p_dbl_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_rate_o && !flyback_i) |-> drv_en_o);

    // R4: request holds until calibration reports done
    p_cal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req_o && !cal_done_i) |=> cal_req_o);

    // R2: a status read clears the flag
    p_por_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i |=> !por_flag_o);

    // R2: once cleared the flag stays cleared
    p_por_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !por_flag_o |=> !por_flag_o);
endmodule

bind hds_seq hds_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_done_i (cal_done_i),
    .flyback_i  (flyback_i),
    .stat_rd_i  (stat_rd_i),
    .drv_en_o   (drv_en_o),
    .dbl_rate_o (dbl_rate_o),
    .cal_req_o  (cal_req_o),
    .por_flag_o (por_flag_o)
);

// File: tb/sim_hds_seq.sv
module sim_hds_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NSUB  = 20;
    localparam int SW    = 8;
    localparam int SOFT  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sub_load = 1'b0;
    logic [SW-1:0] sub = '0;
    logic byte_wr = 1'b0;
    logic tick = 1'b0;
    logic cal_done = 1'b0;
    logic locked = 1'b1;
    logic flyback = 1'b0;
    logic stat_rd = 1'b0;
    logic drv, dbl, calr, por;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hds_seq #(.NUM_SUB(NSUB), .SUB_W(SW), .SOFT_LINES(SOFT)) u0 (
        .clk(clk), .rst_n(rst_n), .sub_load_i(sub_load), .sub_i(sub),
        .byte_wr_i(byte_wr), .line_tick_i(tick), .cal_done_i(cal_done),
        .locked_i(locked), .flyback_i(flyback), .stat_rd_i(stat_rd),
        .drv_en_o(drv), .dbl_rate_o(dbl), .cal_req_o(calr), .por_flag_o(por)
    );

    // Behavioural reference: 0 waiting, 1 calibrating, 2 soft start, 3 running, 4 soft stop
    int m_st, m_ptr, m_cnt, m_a;
    bit [NSUB-1:0] m_seen;
    bit m_por, m_full, m_fin;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_cnt = 0; m_seen = '0; m_por = 1;
        end else begin
            m_full = &m_seen;
            m_fin = 0;
            if (m_st == 2 || m_st == 4) begin
                if (tick) begin
                    if (m_cnt == SOFT - 1) begin m_fin = 1; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
            end else m_cnt = 0;
            case (m_st)
                0: if (m_full) m_st = 1;
                1: if (cal_done) m_st = 2;
                2: if (m_fin) m_st = 3;
                3: if (!locked) m_st = 4;
                4: if (m_fin) m_st = 1;
                default: m_st = 0;
            endcase
            if (stat_rd) m_por = 0;
            m_a = sub_load ? int'(sub) : m_ptr;
            if (sub_load) m_ptr = int'(sub);
            if (byte_wr) begin
                if (m_a < NSUB) m_seen[m_a] = 1;
                m_ptr = (m_a + 1) % (1 << SW);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!finished) begin
            chk("R8 drive", int'(drv), int'((m_st == 2 || m_st == 3 || m_st == 4) && !flyback));
            chk("R6 rate", int'(dbl), int'(m_st == 2 || m_st == 4));
            chk("R4 calreq", int'(calr), int'(m_st == 1));
            chk("R2 flag", int'(por), int'(m_por));
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr_seq(input int start, input int count);
        sub_load = 1; sub = SW'(start);
        cyc();
        sub_load = 0;
        byte_wr = 1;
        repeat (count) cyc();
        byte_wr = 0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick = 1; cyc();
            tick = 0; cyc();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 drive", int'(drv), 0);
        chk("R1 rate", int'(dbl), 0);
        chk("R1 calreq", int'(calr), 0);
        chk("R1 flag", int'(por), 1);
        cyc();
        stat_rd = 1; cyc(); stat_rd = 0;
        @(negedge clk); chk("R2 cleared", int'(por), 0);
        cyc();
        // Write all but the last subaddress
        wr_seq(0, NSUB - 1);
        cyc(); cyc();
        @(negedge clk); chk("R3 partial set", int'(calr), 0);
        cyc();
        wr_seq(NSUB, 3);
        wr_seq(254, 3);
        cyc(); cyc();
        @(negedge clk); chk("R3 out of range", int'(calr), 0);
        cyc();
        // Load and write in one cycle completes the set
        sub_load = 1; byte_wr = 1; sub = SW'(NSUB - 1);
        cyc();
        sub_load = 0; byte_wr = 0;
        @(negedge clk); chk("R4 one cycle later", int'(calr), 0);
        @(negedge clk); chk("R4 request", int'(calr), 1);
        cyc();
        ticks(3);
        @(negedge clk); chk("R5 no drive", int'(drv), 0);
        cyc();
        cal_done = 1; cyc(); cal_done = 0;
        @(negedge clk);
        chk("R6 start drive", int'(drv), 1);
        chk("R6 start rate", int'(dbl), 1);
        cyc();
        locked = 0; cyc(); cyc(); locked = 1;
        @(negedge clk); chk("R9 start kept", int'(dbl), 1);
        cyc();
        ticks(3);
        @(negedge clk); chk("R11 count", int'(dbl), 1);
        cyc();
        ticks(1);
        @(negedge clk); chk("R6 normal rate", int'(dbl), 0);
        chk("R6 normal drive", int'(drv), 1);
        cyc();
        flyback = 1;
        @(negedge clk); chk("R8 masked", int'(drv), 0);
        cyc();
        flyback = 0;
        @(negedge clk); chk("R8 restored", int'(drv), 1);
        cyc();
        locked = 0; cyc(); locked = 1;
        @(negedge clk);
        chk("R7 stop rate", int'(dbl), 1);
        chk("R7 stop drive", int'(drv), 1);
        cyc();
        ticks(SOFT);
        @(negedge clk);
        chk("R7 off", int'(drv), 0);
        chk("R7 recal", int'(calr), 1);
        cyc();
        cal_done = 1; cyc(); cal_done = 0;
        ticks(2);
        rst_n = 0;
        @(negedge clk);
        chk("R10 drive", int'(drv), 0);
        chk("R10 flag", int'(por), 1);
        cyc();
        rst_n = 1;
        cyc();
        wr_seq(0, NSUB - 1);
        cyc(); cyc(); cyc();
        @(negedge clk); chk("R10 rewrite needed", int'(calr), 0);
        cyc();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule